// File: doc/BRIEF.md
# Link Wake-Up Signal Generator

This block sits in the physical layer of a serial-bus node and decides when the sleeping link-layer controller must be woken. It watches whether the link is up (its power-status indication is active and the software link-control bit is set), a one-cycle pulse from the packet decoder that says a link-on packet for this node arrived, a handful of interrupt status bits, an enable for the resume-related interrupts, and a one-cycle bus-reset pulse.

While a wake is wanted and the link is down, the block drives a square wave with a period of eight system clocks. It starts with four high cycles. Otherwise the wave output is held low. A separate enable output is low during hardware reset, so the pad can float there.

The wake causes clear in different ways. A link-on packet sets a sticky flag. That flag is dropped when the link comes up or when a bus reset occurs. Interrupt causes are not stored in the block: they act for as long as their status bits stay set. This means they survive a bus reset, and they take effect as soon as the link goes down again.

Top module: `link_wake_gen`

## Requirements
- R1: The link counts as up only when `lps_active` and `lctrl_bit` are both 1. With no wake cause present, `wake_out` is 0 and `wake_oe` is 1 after reset.
- R2: While `rst_n` is 0, `wake_oe` and `wake_out` are both 0. `wake_oe` becomes 1 at the first clock edge after `rst_n` rises.
- R3: While a wake is active, `wake_out` repeats the pattern of 4 cycles high followed by 4 cycles low (period `PERIOD` = 8). The first active cycle is high.
- R4: A `linkon_rx` pulse while the link is down makes `wake_out` go high in the cycle after the pulse. The wake continues after the pulse has ended.
- R5: `irq_port_evt` = 1 while the link is down causes a wake. This does not depend on `resume_irq_en`.
- R6: `irq_cfg_tmo`, `irq_cable_pwr` and `irq_state_tmo` cause a wake only while `resume_irq_en` = 1. With the enable at 0 they have no effect on `wake_out`.
- R7: A wake stops, and `wake_out` is 0 from the next cycle, once the link is up. If only one of `lps_active` and `lctrl_bit` is 1, the wake does not stop.
- R8: A `bus_reset` pulse ends a wake whose only cause is a link-on packet. A link-on pulse that arrives in the same cycle as a bus reset is discarded.
- R9: A `bus_reset` pulse does not interrupt a wake caused by an interrupt. The wave continues without a phase break.
- R10: If an interrupt cause is present while the link is up, `wake_out` stays 0. A wake starts in the cycle after the link goes down.
- R11: A `linkon_rx` pulse received while the link is up is discarded. Taking the link down later starts no wake.
- R12: Every new activation restarts the wave phase, so each wake begins with 4 high cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| lps_active | input | 1 | Link power status is active |
| lctrl_bit | input | 1 | Link-control register bit |
| linkon_rx | input | 1 | One-cycle pulse: link-on packet for this node received |
| irq_port_evt | input | 1 | Port-event interrupt status |
| irq_cfg_tmo | input | 1 | Configuration-timeout interrupt status |
| irq_cable_pwr | input | 1 | Cable-power-status interrupt status |
| irq_state_tmo | input | 1 | State-timeout interrupt status |
| resume_irq_en | input | 1 | Enable for the three resume-related interrupts |
| bus_reset | input | 1 | One-cycle pulse: bus reset occurred |
| wake_out | output | 1 | Wake square wave toward the link controller |
| wake_oe | output | 1 | Output enable for the wake pad, low during reset |

## Verification
The assertions check these properties on every cycle:
- the output is silent the cycle after the link is up;
- no wake comes from missing causes or from gated interrupts;
- a bus reset with no interrupt cause ends the wave, and an interrupt wake survives it;
- every falling edge of the wave lands at the half-period point.

Some behaviours only show up across a sequence of stimulus, so only the bench scenarios can expose them:
- the exact high and low run lengths;
- the phase restart on reactivation;
- a cause that was hidden while the link was up and fires when it drops;
- a link-on pulse discarded when it collides with a bus reset.

// File: rtl/link_wake_gen.sv
module link_wake_gen #(
  parameter int PERIOD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lps_active,
  input  logic lctrl_bit,
  input  logic linkon_rx,
  input  logic irq_port_evt,
  input  logic irq_cfg_tmo,
  input  logic irq_cable_pwr,
  input  logic irq_state_tmo,
  input  logic resume_irq_en,
  input  logic bus_reset,
  output logic wake_out,
  output logic wake_oe
);
  localparam int HALF = PERIOD / 2;
  localparam int PW   = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [PW-1:0] LAST  = PW'(PERIOD - 1);
  localparam logic [PW-1:0] HALFV = PW'(HALF);

  logic          link_up;
  logic          irq_cause;
  logic          linkon_flag, linkon_next;
  logic          wake_act, wake_next;
  logic [PW-1:0] phase;
  logic          oe_q;

  assign link_up     = lps_active & lctrl_bit;
  assign irq_cause   = irq_port_evt |
                       (resume_irq_en & (irq_cfg_tmo | irq_cable_pwr | irq_state_tmo));
  assign linkon_next = (link_up | bus_reset) ? 1'b0 : (linkon_flag | linkon_rx);
  assign wake_next   = ~link_up & (irq_cause | linkon_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      linkon_flag <= 1'b0;
      wake_act    <= 1'b0;
      phase       <= '0;
      oe_q        <= 1'b0;
    end else begin
      linkon_flag <= linkon_next;
      wake_act    <= wake_next;
      oe_q        <= 1'b1;
      if (!wake_next || !wake_act) phase <= '0;
      else                         phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end
  end

  assign wake_out = wake_act & (phase < HALFV);
  assign wake_oe  = oe_q;

  assert_oe_after_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> wake_oe);

  assert_idle_no_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_cause && !linkon_rx && !linkon_flag) |=> !wake_out);

  assert_fall_at_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wake_out) && wake_act) |-> (phase == HALFV));

  assert_quiet_link_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
    link_up |=> !wake_out);

  assert_gated_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_port_evt && !resume_irq_en && !linkon_rx && !linkon_flag) |=> !wake_out);

  assert_busreset_cancels_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && !irq_cause) |=> !wake_out);

  assert_irq_survives_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && irq_cause && !link_up) |=> wake_act);
endmodule

// File: tb/link_wake_gen_bench.sv
module link_wake_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lpo = 0, lcb = 0, lo = 0, pe = 0, ci = 0, cp = 0, si = 0, en = 0, br = 0;
  logic wake_out, wake_oe;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  link_wake_gen u_link_wake_gen (
    .clk(clk), .rst_n(rst_n), .lps_active(lpo), .lctrl_bit(lcb),
    .linkon_rx(lo), .irq_port_evt(pe), .irq_cfg_tmo(ci), .irq_cable_pwr(cp),
    .irq_state_tmo(si), .resume_irq_en(en), .bus_reset(br),
    .wake_out(wake_out), .wake_oe(wake_oe)
  );

  // behavioural reference
  bit m_flag, m_on, m_oe;
  int m_ticks;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag = 0; m_on = 0; m_oe = 0; m_ticks = 0;
    end else begin
      bit up, irq, nxt;
      up  = lpo && lcb;
      irq = pe || (en && (ci || cp || si));
      if (up || br) m_flag = 0;
      else if (lo)  m_flag = 1;
      nxt = !up && (irq || m_flag);
      if (nxt && !m_on) m_ticks = 0;
      else if (nxt)     m_ticks = m_ticks + 1;
      m_on = nxt;
      m_oe = 1;
    end
  end

  function automatic bit exp_out();
    return m_on && ((m_ticks % 8) < 4);
  endfunction

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checks++;
      if (wake_out !== exp_out() || wake_oe !== m_oe) begin
        fails++;
        $display("FAIL %s: wake_out=%b oe=%b expected wake_out=%b oe=%b at %0t",
                 cur_req, wake_out, wake_oe, exp_out(), m_oe, $time);
      end
    end
  endtask

  task automatic pulse_lo();  lo = 1; cyc(1); lo = 0; endtask
  task automatic pulse_br();  br = 1; cyc(1); br = 0; endtask
  task automatic link_up();   lpo = 1; lcb = 1; endtask
  task automatic link_down(); lpo = 0; lcb = 0; endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R2: reset keeps pad disabled and low
    cur_req = "R2"; cyc(3);
    rst_n = 1; cyc(2);
    // R1: no cause, idle low
    cur_req = "R1"; cyc(4);
    lpo = 1; cyc(3); lpo = 0; lcb = 1; cyc(3); lcb = 0;
    // R4 and R3: link-on wake, wave shape
    cur_req = "R4"; pulse_lo(); cyc(2);
    cur_req = "R3"; cyc(20);
    // R7: one half of link-up is not enough, both stop it
    cur_req = "R7"; lpo = 1; cyc(5); lpo = 0; lcb = 1; cyc(3);
    lpo = 1; cyc(4); link_down(); cyc(4);
    // R8: bus reset cancels link-on wake
    cur_req = "R8"; pulse_lo(); cyc(6); pulse_br(); cyc(5);
    lo = 1; br = 1; cyc(1); lo = 0; br = 0; cyc(6);
    // R5: port event irq, independent of enable
    cur_req = "R5"; en = 0; pe = 1; cyc(12); pe = 0; cyc(3);
    // R6: gated interrupts
    cur_req = "R6";
    ci = 1; cyc(5); ci = 0; cp = 1; cyc(5); cp = 0; si = 1; cyc(5); si = 0;
    en = 1; ci = 1; cyc(9); ci = 0; cp = 1; cyc(4); cp = 0; si = 1; cyc(4); si = 0; cyc(3);
    en = 0;
    // R9: bus reset during irq wake keeps phase
    cur_req = "R9"; pe = 1; cyc(6); pulse_br(); cyc(10); pe = 0; cyc(2);
    // R10: irq hidden while link up, fires on link drop
    cur_req = "R10"; link_up(); cyc(2); pe = 1; cyc(6); lcb = 0; cyc(10);
    lcb = 1; cyc(3); pe = 0; link_down(); cyc(3);
    // R11: link-on while link up is discarded
    cur_req = "R11"; link_up(); cyc(2); pulse_lo(); cyc(2); link_down(); cyc(8);
    // R12: phase restarts on each activation
    cur_req = "R12"; pe = 1; cyc(6); pe = 0; cyc(2); pe = 1; cyc(10);
    pe = 0; cyc(1); pe = 1; cyc(9); pe = 0; cyc(2);
    // R2: reset again mid-wake
    cur_req = "R2"; pe = 1; cyc(3); rst_n = 0; cyc(3); rst_n = 1; cyc(6); pe = 0; cyc(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule